// File: doc/BRIEF.md
# Multi-level page table walker

This block turns a virtual page number into a final page table entry by following a chain of descriptors in memory. A walk begins at a per-process context table. The table base and the process selector are taken in with the request. The word read there is the root descriptor. From it the walker follows up to three levels of page tables, with one word read at each step. It decodes every fetched word by its type field. A pointer moves the walk one level down. An entry ends the walk with a translation. An invalid or reserved word ends it with a fault.

When an entry is found, the walker checks the requested access against the entry's permission bits. It sets the reference bit, and also the modify bit for a write. If either bit changed, it writes the updated entry back to the same memory word before it reports. An entry found above the last level maps a larger region. The index bits that were not used are merged into the low bits of the returned frame number. Only one walk is in flight at a time. The memory side is a plain request/response port: one word per request, one response per request.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from that point until `done_valid` has pulsed, and it is high again in the cycle after the pulse.
- R2: The first read goes to `ctx_table_base + ctx_sel`. Each later read goes to the pointer field of the previous word (bits 31:2, a word address) plus the index for the next level. The indexes are: level 1 from `req_vpn[19:12]`, level 2 from `req_vpn[11:6]`, level 3 from `req_vpn[5:0]`. At most one memory request is outstanding.
- R3: The type field is in bits 1:0, coded 0 invalid, 1 pointer, 2 entry, 3 reserved. An invalid or reserved word at any level ends the walk with fault code 1. So does a pointer at level 3. The reported level is the level of that word (0 for the context table).
- R4: If `req_vpn[19:12]` is at least `L1_LIMIT` (192 by default), the walk ends with fault code 3. No memory access is made, and `done_valid` is high in the cycle right after acceptance.
- R5: Entry permission bits 2, 3 and 4 allow read, write and execute. `req_kind` is coded 0 read, 1 write, 2 execute, 3 none allowed. A denied access ends with fault code 2 and no write to memory.
- R6: On success the fault code is 0 and `done_level` is the level where the entry was found. `done_ppn` is the entry's bits 31:8, with its low bits replaced by the same low bits of `req_vpn`: 20 bits at level 0, 12 at level 1, 6 at level 2, none at level 3.
- R7: On success, bit 5 (reference) is set, and for a write bit 6 (modify) is also set. `done_pte` is the updated entry. If the word changed, it is written to the address it was read from before `done_valid`.
- R8: If the reference and modify bits already hold their final values, no write is made. On any fault, `done_ppn` and `done_pte` are zero.
- R9: `done_valid` is a one-cycle pulse in the cycle after the last memory response of the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request accepted when both high |
| req_vpn | input | 20 | Virtual page number to resolve |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 none |
| ctx_table_base | input | 30 | Word address of the context table |
| ctx_sel | input | 4 | Process selector, index into the context table |
| mem_req_valid | output | 1 | Memory request, one cycle per access |
| mem_req_write | output | 1 | High for the entry write-back |
| mem_req_addr | output | 30 | Word address of the access |
| mem_req_wdata | output | 32 | Updated entry for a write-back |
| mem_rsp_valid | input | 1 | Memory response, one per request |
| mem_rsp_data | input | 32 | Word read |
| done_valid | output | 1 | Result pulse |
| done_fault | output | 2 | 0 none, 1 validation, 2 protection, 3 bounds |
| done_level | output | 2 | Level of the terminating word |
| done_ppn | output | 24 | Frame number with pass-through index bits |
| done_pte | output | 32 | Entry with updated reference and modify bits |

## Verification
The bench memory answers every request exactly one cycle after it is issued, so each access costs two clock edges. The result of a walk with n memory accesses (reads plus a possible write-back) is therefore due just after the 2n-th rising edge that follows the accepting edge. A bounds fault, with n equal to zero, is due right after the accepting edge itself. The bench counts rising edges from acceptance and samples on falling edges. It compares the edge count with 2n, where n comes from the level and outcome it expects. It also checks the fault code, level, frame number, entry and access counts, and the memory word left behind.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // descriptor word layout
  localparam int TYPE_W  = 2;
  localparam int PTR_LSB = 2;
  localparam int ACC_LSB = 2;
  localparam int REF_BIT = 5;
  localparam int MOD_BIT = 6;
  localparam int PPN_LSB = 8;

  typedef enum logic [1:0] {
    DT_INVALID = 2'd0,
    DT_PTR     = 2'd1,
    DT_ENTRY   = 2'd2,
    DT_RSVD    = 2'd3
  } dtype_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_VALID  = 2'd1,
    FLT_PROT   = 2'd2,
    FLT_BOUNDS = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_EXEC  = 2'd2,
    KIND_NONE  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WALK  = 2'd1,
    ST_WBACK = 2'd2,
    ST_DONE  = 2'd3
  } state_e;

endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
  parameter int CTX_W = 4,
  parameter int L1_W  = 8,
  parameter int L2_W  = 6,
  parameter int L3_W  = 6,
  parameter int MA_W  = 30
) (
  input  logic [1:0]                 level,
  input  logic [MA_W-1:0]            base,
  input  logic [CTX_W-1:0]           ctx,
  input  logic [L1_W+L2_W+L3_W-1:0]  vpn,
  output logic [MA_W-1:0]            addr
);

  localparam int VPN_W = L1_W + L2_W + L3_W;

  logic [MA_W-1:0] offs;

  // level 0 indexes the context table, deeper levels index by VPN slice
  always_comb begin
    unique case (level)
      2'd0:    offs = MA_W'(ctx);
      2'd1:    offs = MA_W'(vpn[VPN_W-1 -: L1_W]);
      2'd2:    offs = MA_W'(vpn[L2_W+L3_W-1 -: L2_W]);
      default: offs = MA_W'(vpn[L3_W-1:0]);
    endcase
  end

  assign addr = base + offs;

endmodule

// File: rtl/ptw_desc_check.sv
module ptw_desc_check
  import ptw_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int MA_W   = 30
) (
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        kind,
  output logic [1:0]        dtype,
  output logic              allow,
  output logic [WORD_W-1:0] upd_word,
  output logic              wb_need,
  output logic [MA_W-1:0]   next_ptr
);

  logic [WORD_W-1:0] set_mask;

  assign dtype    = word[TYPE_W-1:0];
  assign next_ptr = word[PTR_LSB +: MA_W];

  always_comb begin
    unique case (kind)
      KIND_READ:  allow = word[ACC_LSB];
      KIND_WRITE: allow = word[ACC_LSB+1];
      KIND_EXEC:  allow = word[ACC_LSB+2];
      default:    allow = 1'b0;
    endcase
  end

  always_comb begin
    set_mask          = '0;
    set_mask[REF_BIT] = 1'b1;
    set_mask[MOD_BIT] = (kind == KIND_WRITE);
  end

  assign upd_word = word | set_mask;
  assign wb_need  = (upd_word != word);

endmodule

// File: rtl/ptw_ppn_merge.sv
module ptw_ppn_merge #(
  parameter int PPN_W = 24,
  parameter int L1_W  = 8,
  parameter int L2_W  = 6,
  parameter int L3_W  = 6
) (
  input  logic [PPN_W-1:0]           ppn,
  input  logic [L1_W+L2_W+L3_W-1:0]  vpn,
  input  logic [1:0]                 level,
  output logic [PPN_W-1:0]           merged
);

  localparam int VPN_W = L1_W + L2_W + L3_W;

  int thresh;

  // number of low VPN bits that the entry's level leaves unresolved
  always_comb begin
    unique case (level)
      2'd0:    thresh = VPN_W;
      2'd1:    thresh = L2_W + L3_W;
      2'd2:    thresh = L3_W;
      default: thresh = 0;
    endcase
  end

  for (genvar i = 0; i < PPN_W; i++) begin : g_bit
    if (i < VPN_W) begin : g_mix
      assign merged[i] = (i < thresh) ? vpn[i] : ppn[i];
    end else begin : g_keep
      assign merged[i] = ppn[i];
    end
  end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int CTX_W    = 4,
  parameter int L1_W     = 8,
  parameter int L2_W     = 6,
  parameter int L3_W     = 6,
  parameter int PPN_W    = 24,
  parameter int MA_W     = 30,
  parameter int L1_LIMIT = 192
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [L1_W+L2_W+L3_W-1:0]  req_vpn,
  input  logic [1:0]                 req_kind,
  input  logic [MA_W-1:0]            ctx_table_base,
  input  logic [CTX_W-1:0]           ctx_sel,
  output logic                       mem_req_valid,
  output logic                       mem_req_write,
  output logic [MA_W-1:0]            mem_req_addr,
  output logic [PPN_W+7:0]           mem_req_wdata,
  input  logic                       mem_rsp_valid,
  input  logic [PPN_W+7:0]           mem_rsp_data,
  output logic                       done_valid,
  output logic [1:0]                 done_fault,
  output logic [1:0]                 done_level,
  output logic [PPN_W-1:0]           done_ppn,
  output logic [PPN_W+7:0]           done_pte
);

  localparam int VPN_W  = L1_W + L2_W + L3_W;
  localparam int WORD_W = PPN_W + PPN_LSB;

  state_e             st;
  logic [1:0]         lvl;
  logic [VPN_W-1:0]   vpn_q;
  logic [1:0]         kind_q;
  logic [MA_W-1:0]    cur_addr;

  logic [1:0]         sel_level;
  logic [MA_W-1:0]    sel_base;
  logic [VPN_W-1:0]   sel_vpn;
  logic [MA_W-1:0]    sel_addr;

  logic [1:0]         dc_dtype;
  logic               dc_allow;
  logic [WORD_W-1:0]  dc_upd;
  logic               dc_wb;
  logic [MA_W-1:0]    dc_ptr;
  logic [PPN_W-1:0]   mg_ppn;
  logic               out_of_range;

  assign req_ready = (st == ST_IDLE);

  assign out_of_range = (32'(req_vpn[VPN_W-1 -: L1_W]) >= 32'(L1_LIMIT));

  // address of the next read: context slot when idle, next level otherwise
  assign sel_level = (st == ST_IDLE) ? 2'd0 : (lvl + 2'd1);
  assign sel_base  = (st == ST_IDLE) ? ctx_table_base : dc_ptr;
  assign sel_vpn   = (st == ST_IDLE) ? req_vpn : vpn_q;

  ptw_index_sel #(
    .CTX_W (CTX_W),
    .L1_W  (L1_W),
    .L2_W  (L2_W),
    .L3_W  (L3_W),
    .MA_W  (MA_W)
  ) u_index (
    .level (sel_level),
    .base  (sel_base),
    .ctx   (ctx_sel),
    .vpn   (sel_vpn),
    .addr  (sel_addr)
  );

  ptw_desc_check #(
    .WORD_W (WORD_W),
    .MA_W   (MA_W)
  ) u_check (
    .word     (mem_rsp_data),
    .kind     (kind_q),
    .dtype    (dc_dtype),
    .allow    (dc_allow),
    .upd_word (dc_upd),
    .wb_need  (dc_wb),
    .next_ptr (dc_ptr)
  );

  ptw_ppn_merge #(
    .PPN_W (PPN_W),
    .L1_W  (L1_W),
    .L2_W  (L2_W),
    .L3_W  (L3_W)
  ) u_merge (
    .ppn    (mem_rsp_data[PPN_LSB +: PPN_W]),
    .vpn    (vpn_q),
    .level  (lvl),
    .merged (mg_ppn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      lvl           <= 2'd0;
      vpn_q         <= '0;
      kind_q        <= 2'd0;
      cur_addr      <= '0;
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
      done_valid    <= 1'b0;
      done_fault    <= FLT_NONE;
      done_level    <= 2'd0;
      done_ppn      <= '0;
      done_pte      <= '0;
    end else begin
      mem_req_valid <= 1'b0;
      done_valid    <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            vpn_q  <= req_vpn;
            kind_q <= req_kind;
            lvl    <= 2'd0;
            if (out_of_range) begin
              done_fault <= FLT_BOUNDS;
              done_level <= 2'd0;
              done_ppn   <= '0;
              done_pte   <= '0;
              done_valid <= 1'b1;
              st         <= ST_DONE;
            end else begin
              mem_req_valid <= 1'b1;
              mem_req_write <= 1'b0;
              mem_req_addr  <= sel_addr;
              cur_addr      <= sel_addr;
              st            <= ST_WALK;
            end
          end
        end
        ST_WALK: begin
          if (mem_rsp_valid) begin
            unique case (dc_dtype)
              DT_PTR: begin
                if (lvl == 2'd3) begin
                  done_fault <= FLT_VALID;
                  done_level <= lvl;
                  done_ppn   <= '0;
                  done_pte   <= '0;
                  done_valid <= 1'b1;
                  st         <= ST_DONE;
                end else begin
                  lvl           <= lvl + 2'd1;
                  mem_req_valid <= 1'b1;
                  mem_req_write <= 1'b0;
                  mem_req_addr  <= sel_addr;
                  cur_addr      <= sel_addr;
                end
              end
              DT_ENTRY: begin
                done_level <= lvl;
                if (!dc_allow) begin
                  done_fault <= FLT_PROT;
                  done_ppn   <= '0;
                  done_pte   <= '0;
                  done_valid <= 1'b1;
                  st         <= ST_DONE;
                end else begin
                  done_fault <= FLT_NONE;
                  done_ppn   <= mg_ppn;
                  done_pte   <= dc_upd;
                  if (dc_wb) begin
                    mem_req_valid <= 1'b1;
                    mem_req_write <= 1'b1;
                    mem_req_addr  <= cur_addr;
                    mem_req_wdata <= dc_upd;
                    st            <= ST_WBACK;
                  end else begin
                    done_valid <= 1'b1;
                    st         <= ST_DONE;
                  end
                end
              end
              default: begin
                done_fault <= FLT_VALID;
                done_level <= lvl;
                done_ppn   <= '0;
                done_pte   <= '0;
                done_valid <= 1'b1;
                st         <= ST_DONE;
              end
            endcase
          end
        end
        ST_WBACK: begin
          if (mem_rsp_valid) begin
            mem_req_write <= 1'b0;
            done_valid    <= 1'b1;
            st            <= ST_DONE;
          end
        end
        default: begin
          st <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       mem_req_valid,
  input logic       mem_req_write,
  input logic       wb_ref,
  input logic       done_valid,
  input logic [1:0] done_fault
);

  // R1
  busy_noready_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R2
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  // R4
  bounds_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_fault == 2'd3) |-> $past(req_valid && req_ready));

  // R7
  wb_ref_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_write) |-> wb_ref);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> req_ready);

endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_write (mem_req_write),
  .wb_ref        (mem_req_wdata[5]),
  .done_valid    (done_valid),
  .done_fault    (done_fault)
);

// File: tb/ptw_walker_test.sv
module ptw_walker_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_vpn = '0;
  logic [1:0]  req_kind = '0;
  logic [29:0] ctx_table_base = '0;
  logic [3:0]  ctx_sel = '0;
  logic        mem_req_valid, mem_req_write;
  logic [29:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done_valid;
  logic [1:0]  done_fault, done_level;
  logic [23:0] done_ppn;
  logic [31:0] done_pte;

  int n_chk = 0;
  int n_bad = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  int cyc = 0;
  bit finished = 0;

  logic [31:0] mem [0:1023];

  always #5 clk = ~clk;

  ptw_walker uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_kind(req_kind), .ctx_table_base(ctx_table_base),
    .ctx_sel(ctx_sel), .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_valid(done_valid), .done_fault(done_fault), .done_level(done_level),
    .done_ppn(done_ppn), .done_pte(done_pte)
  );

  // memory: one response, one cycle after each request
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid) begin
      mem_rsp_valid <= 1'b1;
      if (mem_req_write) begin
        mem[mem_req_addr[9:0]] = mem_req_wdata;
        wr_cnt = wr_cnt + 1;
        mem_rsp_data <= 32'h0;
      end else begin
        mem_rsp_data <= mem[mem_req_addr[9:0]];
        rd_cnt = rd_cnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 190000 && !finished) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog act=%0d exp=<190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ptd(input int base);
    return {30'(base), 2'b01};
  endfunction

  // issue one walk, count edges from acceptance to the result
  task automatic walk(input logic [3:0] ctx, input logic [19:0] vpn, input logic [1:0] kind,
                      output int lat, output bit busy_ok);
    @(negedge clk);
    rd_cnt = 0;
    wr_cnt = 0;
    ctx_sel = ctx;
    req_vpn = vpn;
    req_kind = kind;
    req_valid = 1'b1;
    busy_ok = 1;
    lat = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done_valid && lat < 60) begin
      if (req_ready) busy_ok = 0;
      @(posedge clk);
      lat = lat + 1;
      @(negedge clk);
    end
  endtask

  initial begin
    int it = 0;
    int lat;
    bit busy_ok;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset ready", 32'(req_ready), 32'd1);
    chk("R9 reset done", 32'(done_valid), 32'd0);
    chk("R2 reset memreq", 32'(mem_req_valid), 32'd0);

    for (int t = 0; t < 4; t++) begin
      for (int ty = 0; ty < 4; ty++) begin
        if (ty == 1 && t != 3) continue;
        for (int acc = 0; acc < 8; acc++) begin
          for (int kind = 0; kind < 4; kind++) begin
            for (int rm = 0; rm < 4; rm++) begin
              logic [3:0]  ctx;
              logic [7:0]  l1;
              logic [5:0]  l2, l3;
              logic [19:0] vpn;
              logic [23:0] ppn, exp_ppn, mask;
              logic [31:0] term, exp_pte, exp_mem;
              logic [1:0]  exp_f, newrm;
              int eaddr, exp_rd, exp_wr, pass;
              bit allow;
              it = it + 1;
              ctx = 4'(it);
              l1 = 8'((it * 37) % 192);
              l2 = 6'((it * 11) % 64);
              l3 = 6'((it * 23) % 64);
              vpn = {l1, l2, l3};
              ppn = 24'hA5C3F0 ^ 24'(it * 4951);
              if (ty == 2) term = {ppn, 1'(it), rm[1], rm[0], 3'(acc), 2'b10};
              else         term = {ppn, 6'b0, 2'(ty)};
              eaddr = (t == 0) ? int'(ctx) : (t == 1) ? 256 + l1 : (t == 2) ? 512 + l2 : 640 + l3;
              mem[ctx] = (t == 0) ? term : ptd(256);
              if (t >= 1) mem[256 + l1] = (t == 1) ? term : ptd(512);
              if (t >= 2) mem[512 + l2] = (t == 2) ? term : ptd(640);
              if (t == 3) mem[640 + l3] = term;

              exp_rd = t + 1;
              exp_wr = 0;
              exp_ppn = '0;
              exp_pte = '0;
              exp_mem = term;
              if (ty == 2) begin
                allow = (kind == 3) ? 1'b0 : 1'(acc >> kind);
                if (!allow) exp_f = 2'd2;
                else begin
                  exp_f = 2'd0;
                  newrm = rm | 2'b01 | ((kind == 1) ? 2'b10 : 2'b00);
                  exp_wr = (newrm != 2'(rm)) ? 1 : 0;
                  exp_pte = {term[31:7], newrm[1], newrm[0], term[4:0]};
                  exp_mem = exp_pte;
                  pass = (t == 0) ? 20 : (t == 1) ? 12 : (t == 2) ? 6 : 0;
                  mask = 24'((32'd1 << pass) - 1);
                  exp_ppn = (ppn & ~mask) | (24'(vpn) & mask);
                end
              end else exp_f = 2'd1;

              walk(ctx, vpn, 2'(kind), lat, busy_ok);
              chk(ty == 2 ? "R5 fault" : "R3 fault", 32'(done_fault), 32'(exp_f));
              chk("R6 level", 32'(done_level), 32'(t));
              chk(exp_f == 0 ? "R6 ppn" : "R8 fault ppn", 32'(done_ppn), 32'(exp_ppn));
              chk(exp_f == 0 ? "R7 pte" : "R8 fault pte", done_pte, exp_pte);
              chk("R2 reads", 32'(rd_cnt), 32'(exp_rd));
              chk(exp_wr == 1 ? "R7 writeback" : "R8 no write", 32'(wr_cnt), 32'(exp_wr));
              chk("R7 memory word", mem[eaddr], exp_mem);
              chk("R9 latency", 32'(lat), 32'(2 * (exp_rd + exp_wr)));
              chk("R1 busy", 32'(busy_ok), 32'd1);
              @(negedge clk);
              chk("R1 ready after done", 32'(req_ready), 32'd1);
            end
          end
        end
      end
    end

    for (int b = 192; b < 256; b++) begin
      logic [19:0] vpn;
      vpn = {8'(b), 6'(b), 6'(b * 3)};
      walk(4'(b), vpn, 2'(b % 4), lat, busy_ok);
      chk("R4 fault", 32'(done_fault), 32'd3);
      chk("R4 level", 32'(done_level), 32'd0);
      chk("R4 no access", 32'(rd_cnt + wr_cnt), 32'd0);
      chk("R4 latency", 32'(lat), 32'd0);
      chk("R8 bounds pte", done_pte, 32'd0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule